// File: doc/BRIEF.md
# JTAG Adaptive-Clock Target Synchronizer

This block sits on the target side of a JTAG link. It brings the asynchronous TCK, TMS and TDI inputs into the core clock domain through a chain of flip-flops clocked by the core clock. The last stage of the TCK chain is sent back to the host as the return clock RTCK. A host that waits for each TCK edge to reappear on RTCK before it drives the next edge runs TCK as fast as the core clock allows, and no faster. That limit is the core frequency divided by twice the stage count.

The block also turns the synchronized TCK into single-cycle rising and falling strobes in the core domain. It captures TMS and TDI on the rising strobe, which matches normal JTAG sampling on the rising TCK edge. The TAP state machine and the logic behind it use these strobes and captured bits. An active-low test reset (TRST) clears every stage asynchronously, and so does the core reset.

Top module: `jtag_adaptive_sync`

## Requirements
- R1: While coreRstN is low, rtck, tckRise, tckFall, tmsSync and tdiSync are all 0.
- R2: While trstN is low, every synchronizer stage and capture register is held at 0. rtck, tckRise, tckFall, tmsSync and tdiSync stay 0 even if tckIn toggles.
- R3: A level change on tckIn that is stable before a core clock edge appears on rtck exactly SYNC_STAGES core clock rising edges later, counting that edge as the first.
- R4: tckRise is 1 for exactly one core cycle, the same cycle in which rtck changes from 0 to 1.
- R5: tckFall is 1 for exactly one core cycle, the same cycle in which rtck changes from 1 to 0.
- R6: tckRise and tckFall are never 1 in the same cycle, and neither is 1 in two consecutive cycles.
- R7: In the cycle in which tckRise is 1, tmsSync and tdiSync take the tmsIn and tdiIn levels that were present when tckIn rose. This holds provided those levels are held for the synchronizer delay.
- R8: In any cycle in which tckRise is 0, tmsSync and tdiSync keep their previous values. This includes the cycles around falling edges and idle periods.
- R9: A host that drives each TCK edge only after the previous edge has reappeared on rtck completes one full TCK period in 2·SYNC_STAGES core cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| coreClk | input | 1 | Target core clock; all stages sample on its rising edge |
| coreRstN | input | 1 | Active-low asynchronous core reset |
| tckIn | input | 1 | Test clock from the host, asynchronous to coreClk |
| tmsIn | input | 1 | Test mode select from the host, asynchronous |
| tdiIn | input | 1 | Test data in from the host, asynchronous |
| trstN | input | 1 | Active-low asynchronous test reset |
| rtck | output | 1 | Return clock: the last TCK synchronizer stage |
| tmsSync | output | 1 | TMS captured at the synchronized TCK rising edge |
| tdiSync | output | 1 | TDI captured at the synchronized TCK rising edge |
| tckRise | output | 1 | One-cycle strobe for a synchronized TCK rising edge |
| tckFall | output | 1 | One-cycle strobe for a synchronized TCK falling edge |

## Verification
The embedded assertions check on every core cycle the following properties:
- The strobes line up with the transitions of rtck.
- The strobes are exclusive and last one cycle.
- The captured TMS/TDI values hold between rising strobes.
- The outputs are held at zero under test reset.

The exact echo latency of SYNC_STAGES cycles, the full-period length under a handshaking host, and the correct capture of each TMS/TDI bit are shown only by the bench. Its driver acts as an adaptive host and queues every bit it sends.

// File: rtl/jas_pkg.sv
package jas_pkg;
  // Edge events seen on the synchronized TCK, from control to datapath
  typedef struct packed {
    logic riseNow;
    logic fallNow;
  } edgeEvt_t;
endpackage

// File: rtl/jas_sync_path.sv
module jas_sync_path
  import jas_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic     clk,
  input  logic     clrN,
  input  logic     tckIn,
  input  logic     tmsIn,
  input  logic     tdiIn,
  input  edgeEvt_t evt,
  output logic     tckPrev,
  output logic     tckLast,
  output logic     tmsSync,
  output logic     tdiSync
);
  localparam int DATA_LANES = 2;
  localparam int DATA_DEPTH = SYNC_STAGES - 1;

  // TCK chain: full SYNC_STAGES depth, last stage is the return clock
  logic [SYNC_STAGES-1:0] tckChain;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) tckChain <= '0;
    else       tckChain <= {tckChain[SYNC_STAGES-2:0], tckIn};
  end

  assign tckPrev = tckChain[SYNC_STAGES-2];
  assign tckLast = tckChain[SYNC_STAGES-1];

  // Data lanes: DATA_DEPTH free-running stages, then an enabled capture
  // stage, so TMS/TDI see the same total depth as TCK
  logic [DATA_LANES-1:0] dataIn;
  logic [DATA_LANES-1:0] dataTap;
  logic [DATA_LANES-1:0] dataCap;

  assign dataIn = {tdiIn, tmsIn};

  for (genvar g = 0; g < DATA_LANES; g++) begin : gLane
    logic [DATA_DEPTH-1:0] laneChain;
    if (DATA_DEPTH > 1) begin : gDeep
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) laneChain <= '0;
        else       laneChain <= {laneChain[DATA_DEPTH-2:0], dataIn[g]};
      end
    end else begin : gShallow
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) laneChain <= '0;
        else       laneChain <= dataIn[g];
      end
    end
    assign dataTap[g] = laneChain[DATA_DEPTH-1];

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN)            dataCap[g] <= 1'b0;
      else if (evt.riseNow) dataCap[g] <= dataTap[g];
    end
  end

  assign tmsSync = dataCap[0];
  assign tdiSync = dataCap[1];

  // R2: capture registers are cleared while the chain is held clear
  assert_clear_cap_R2: assert property (@(posedge clk)
    !clrN |-> (dataCap == '0) && (tckChain == '0));
endmodule

// File: rtl/jas_edge_ctrl.sv
module jas_edge_ctrl
  import jas_pkg::*;
(
  input  logic     clk,
  input  logic     clrN,
  input  logic     tckPrev,
  input  logic     tckLast,
  output edgeEvt_t evt,
  output logic     tckRise,
  output logic     tckFall
);
  // Transition about to land on the last stage at the next edge
  always_comb begin
    evt.riseNow = tckPrev & ~tckLast;
    evt.fallNow = ~tckPrev & tckLast;
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      tckRise <= 1'b0;
      tckFall <= 1'b0;
    end else begin
      tckRise <= evt.riseNow;
      tckFall <= evt.fallNow;
    end
  end

  assert_rise_on_rtck_rise_R4: assert property (@(posedge clk) disable iff (!clrN)
    tckRise |-> (tckLast && !$past(tckLast)));

  assert_fall_on_rtck_fall_R5: assert property (@(posedge clk) disable iff (!clrN)
    tckFall |-> (!tckLast && $past(tckLast)));

  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!clrN)
    !(tckRise && tckFall));

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!clrN)
    tckRise |=> !tckRise);

  assert_fall_single_R6: assert property (@(posedge clk) disable iff (!clrN)
    tckFall |=> !tckFall);
endmodule

// File: rtl/jtag_adaptive_sync.sv
module jtag_adaptive_sync
  import jas_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic coreClk,
  input  logic coreRstN,
  input  logic tckIn,
  input  logic tmsIn,
  input  logic tdiIn,
  input  logic trstN,
  output logic rtck,
  output logic tmsSync,
  output logic tdiSync,
  output logic tckRise,
  output logic tckFall
);
  logic     clrN;
  logic     tckPrev;
  logic     tckLast;
  edgeEvt_t evt;

  // Either reset clears all stages asynchronously
  assign clrN = coreRstN & trstN;

  jas_sync_path #(.SYNC_STAGES(SYNC_STAGES)) i_path (
    .clk     (coreClk),
    .clrN    (clrN),
    .tckIn   (tckIn),
    .tmsIn   (tmsIn),
    .tdiIn   (tdiIn),
    .evt     (evt),
    .tckPrev (tckPrev),
    .tckLast (tckLast),
    .tmsSync (tmsSync),
    .tdiSync (tdiSync)
  );

  jas_edge_ctrl i_ctrl (
    .clk     (coreClk),
    .clrN    (clrN),
    .tckPrev (tckPrev),
    .tckLast (tckLast),
    .evt     (evt),
    .tckRise (tckRise),
    .tckFall (tckFall)
  );

  assign rtck = tckLast;

  assert_hold_between_rises_R8: assert property (@(posedge coreClk) disable iff (!clrN)
    !tckRise |-> ($stable(tmsSync) && $stable(tdiSync)));

  assert_trst_quiet_R2: assert property (@(posedge coreClk) disable iff (!coreRstN)
    !trstN |-> (!rtck && !tckRise && !tckFall && !tmsSync && !tdiSync));

  assert_reset_quiet_R1: assert property (@(posedge coreClk)
    !coreRstN |-> (!rtck && !tckRise && !tckFall && !tmsSync && !tdiSync));
endmodule

// File: tb/test_jtag_adaptive_sync.sv
module test_jtag_adaptive_sync;
  localparam int NS = 3;

  logic coreClk = 1'b0;
  logic coreRstN = 1'b0;
  logic tckIn = 1'b0, tmsIn = 1'b0, tdiIn = 1'b0, trstN = 1'b1;
  logic rtck, tmsSync, tdiSync, tckRise, tckFall;

  int checks = 0;
  int errors = 0;
  logic [1:0] expQ[$];
  logic prevValid = 1'b0;
  logic [1:0] prevCap = 2'b00;
  bit done = 1'b0;

  always #5 coreClk = ~coreClk;

  jtag_adaptive_sync #(.SYNC_STAGES(NS)) i_jtag_adaptive_sync (
    .coreClk(coreClk), .coreRstN(coreRstN), .tckIn(tckIn), .tmsIn(tmsIn),
    .tdiIn(tdiIn), .trstN(trstN), .rtck(rtck), .tmsSync(tmsSync),
    .tdiSync(tdiSync), .tckRise(tckRise), .tckFall(tckFall));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected TMS/TDI on each rising strobe, checks hold otherwise
  always @(negedge coreClk) begin
    if (coreRstN && trstN) begin
      if (tckRise) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected rise", 1, 0);
        else begin
          logic [1:0] e;
          e = expQ.pop_front();
          check({tdiSync, tmsSync} == e, "R7 captured tdi/tms", {tdiSync, tmsSync}, e);
        end
      end else if (prevValid) begin
        check({tdiSync, tmsSync} == prevCap, "R8 hold", {tdiSync, tmsSync}, prevCap);
      end
      check(!(tckRise && tckFall), "R6 exclusive", {tckRise, tckFall}, 0);
      prevCap = {tdiSync, tmsSync};
      prevValid = 1'b1;
    end else begin
      prevValid = 1'b0;
    end
  end

  // Adaptive host: one edge, then wait for it to echo on rtck
  task automatic driveEdge(input logic lvl, output int lat);
    int n = 0;
    @(negedge coreClk);
    tckIn = lvl;
    do begin
      @(negedge coreClk);
      n++;
      if (rtck != lvl) begin
        check(!tckRise && !tckFall, "R4/R5 early strobe", {tckRise, tckFall}, 0);
      end
    end while (rtck != lvl && n < 40);
    lat = n;
    check(n == NS, "R3 echo latency", n, NS);
    if (lvl) check(tckRise == 1'b1, "R4 rise with rtck", tckRise, 1);
    else     check(tckFall == 1'b1, "R5 fall with rtck", tckFall, 1);
  endtask

  task automatic jtagCycle(input logic tmsV, input logic tdiV);
    int lh, ll;
    tmsIn = tmsV;
    tdiIn = tdiV;
    expQ.push_back({tdiV, tmsV});
    driveEdge(1'b1, lh);
    driveEdge(1'b0, ll);
    check(lh + ll == 2 * NS, "R9 period", lh + ll, 2 * NS);
  endtask

  initial begin
    repeat (3) @(negedge coreClk);
    check({rtck, tckRise, tckFall, tmsSync, tdiSync} == 5'b0, "R1 reset state",
          {rtck, tckRise, tckFall, tmsSync, tdiSync}, 0);
    tckIn = 1'b1;
    repeat (NS + 2) @(negedge coreClk);
    check(rtck == 1'b0, "R1 rtck held in reset", rtck, 0);
    tckIn = 1'b0;
    #2 coreRstN = 1'b1;
    repeat (2) @(negedge coreClk);

    for (int i = 0; i < 16; i++) begin
      jtagCycle(((i * 5 + 1) % 3) == 0, i[0] ^ i[2]);
    end

    // Idle: no TCK activity, outputs must hold (monitor checks R8)
    repeat (10) @(negedge coreClk);
    check(rtck == 1'b0 && !tckRise, "R8 idle quiet", rtck, 0);

    // Test reset while TCK is high
    jtagCycle(1'b1, 1'b1);
    begin
      int lh;
      tmsIn = 1'b1;
      tdiIn = 1'b1;
      expQ.push_back(2'b11);
      driveEdge(1'b1, lh);
    end
    check(tmsSync && tdiSync, "R7 captured ones", {tdiSync, tmsSync}, 3);
    #2 trstN = 1'b0;
    @(negedge coreClk);
    check({rtck, tmsSync, tdiSync} == 3'b0, "R2 trst clears", {rtck, tmsSync, tdiSync}, 0);
    for (int k = 0; k < 12; k++) begin
      if (k % 2 == 0) tckIn = ~tckIn;
      @(negedge coreClk);
      check({rtck, tckRise, tckFall} == 3'b0, "R2 quiet during trst",
            {rtck, tckRise, tckFall}, 0);
    end
    tckIn = 1'b0;
    repeat (NS + 1) @(negedge coreClk);
    #2 trstN = 1'b1;
    repeat (NS + 2) @(negedge coreClk);
    check(rtck == 1'b0 && tmsSync == 1'b0, "R2 clean release", rtck, 0);

    jtagCycle(1'b0, 1'b1);
    jtagCycle(1'b1, 1'b0);
    repeat (NS + 2) @(negedge coreClk);
    check(expQ.size() == 0, "R7 all bits delivered", expQ.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge coreClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule